// File: doc/BRIEF.md
# Serial Status Command Responder

This block is the management read port of a four- or eight-port twisted-pair repeater. A controller frames a transfer by holding a select line high. It shifts in an 8-bit command one bit per bit strobe, most significant bit first. On the next eight strobes it reads back a response byte, also most significant bit first. The block runs on the system clock. The serial port is seen only as a select level, a one-cycle bit strobe and a data bit.

Each response byte is built from per-port status vectors supplied by the surrounding repeater logic: partition state, link-test state, receive polarity, and FIFO bit-rate error events. The block also holds a jabber-lockup flag and returns a fixed version code. The error and jabber flags are sticky and clear when they are read. When a port's enable rises again, the block holds that port in link-fail and signals the link logic to do the same.

Top module: `serstat_resp`

## Requirements
- R1: Response bit 7 appears on `so_o` on the clock after the 8th command strobe. Each later strobe moves the next lower bit out on the following clock, and the strobe after bit 0 leaves `so_o` at 0. `so_o` changes only after a strobe while selected, and it is 0 on the clock after `cs_i` is seen low.
- R2: Command 0x80 returns partition status. A bit is 1 when the port is connected (`part_i` bit low) and 0 when it is partitioned.
- R3: In the 0x80 response, a port whose `port_en_i` bit is 0 reads as 1 (connected), whatever its `part_i` bit is.
- R4: Command 0xA0 returns the sticky FIFO-error flags, with bit n for port n. A one-cycle pulse on `fifo_err_i[n]` sets flag n.
- R5: Reading 0xA0 clears the error flags in the clock that completes the command. An error pulse arriving in that same clock is kept and reported by the next read.
- R6: Command 0xD0 returns link status, 1 for pass. A disabled port reports its `link_pass_i` value unchanged.
- R7: On the clock after a port's `port_en_i` bit rises, `link_force_o` for that port goes to 1 and the port reads 0 in the 0xD0 response. This hold lasts until `link_pass_i` for that port has been sampled at 0.
- R8: Command 0xE0 returns receive polarity. A bit is 1 only when `pol_rev_i` and `pol_fix_en_i` are both 1 for that port.
- R9: Command 0xF0 returns the sticky jabber flag in bit 7, with bits 6..0 at 0. A pulse on `jabber_i` sets the flag, and reading 0xF0 clears it.
- R10: Command 0xFF returns 0x05: the version code in bits 3..0 and 0 in bits 7..4.
- R11: Any other command returns 0x00 and clears no flag.
- R12: With NPORTS=4, port k is placed at byte bit 2k+1, so bits 7, 5, 3 and 1 carry ports 3, 2, 1 and 0. The even bits read 0.
- R13: Strobes after the 16th in one selected frame are ignored, and `so_o` stays 0 until `cs_i` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Frame select, high for the whole transfer |
| bit_stb_i | input | 1 | One-cycle strobe per serial bit |
| si_i | input | 1 | Serial command bit, sampled with the strobe |
| so_o | output | 1 | Registered serial response bit |
| port_en_i | input | NPORTS | Per-port enable |
| part_i | input | NPORTS | Per-port partitioned state (1 = partitioned) |
| fifo_err_i | input | NPORTS | Per-port FIFO over/underflow event pulse |
| link_pass_i | input | NPORTS | Per-port link-test state (1 = pass) |
| pol_rev_i | input | NPORTS | Per-port reversed polarity detected |
| pol_fix_en_i | input | NPORTS | Per-port polarity correction enabled |
| jabber_i | input | 1 | Jabber lockup event pulse |
| link_force_o | output | NPORTS | Per-port request to hold link-test in fail |

## Verification
The hardest case to reach from the ports is an error pulse landing in the exact clock where a read of the error flags completes. That pulse must survive the clear, while the flags captured in the response are dropped. The bench drives the FIFO-error pulse on the same negative edge that raises the eighth command strobe, so the pulse and the clear meet at one clock edge. It then reads again and expects only the new bit. The re-enable hold is reached by disabling a port, re-enabling it with link still passing, and then showing a link-fail sample for that port before expecting the pass to be reported again.

// File: rtl/serstat_pkg.sv
package serstat_pkg;
  localparam int BYTE_W = 8;
  localparam int NUM_VEC = 4;

  typedef enum logic [BYTE_W-1:0] {
    OP_PART = 8'h80,
    OP_ERR  = 8'hA0,
    OP_LINK = 8'hD0,
    OP_POL  = 8'hE0,
    OP_JAB  = 8'hF0,
    OP_VER  = 8'hFF
  } op_e;

  // index of each per-port vector in the packed set
  localparam int V_PART = 0;
  localparam int V_ERR  = 1;
  localparam int V_LINK = 2;
  localparam int V_POL  = 3;
endpackage

// File: rtl/serstat_shifter.sv
module serstat_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cs_i,
  input  logic         bit_stb_i,
  input  logic         si_i,
  input  logic [W-1:0] resp_i,
  output logic [W-1:0] cmd_o,
  output logic         load_o,
  output logic         so_o
);
  localparam int FRAME = 2 * W;
  localparam int CW    = $clog2(FRAME + 1);

  logic [CW-1:0] cnt_q;
  logic [W-2:0]  cmd_q;
  logic [W-1:0]  sh_q;
  logic          step;
  logic          in_cmd;

  assign step   = cs_i && bit_stb_i && (cnt_q < CW'(FRAME));
  assign in_cmd = cnt_q < CW'(W);
  assign load_o = step && (cnt_q == CW'(W - 1));
  assign cmd_o  = {cmd_q, si_i};

  always_ff @(posedge clk) begin
    if (rst || !cs_i) begin
      cnt_q <= '0;
      cmd_q <= '0;
      sh_q  <= '0;
      so_o  <= 1'b0;
    end else if (step) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q < CW'(W - 1)) begin
        cmd_q <= {cmd_q[W-3:0], si_i};
      end
      if (load_o) begin
        so_o <= resp_i[W-1];
        sh_q <= {resp_i[W-2:0], 1'b0};
      end else if (!in_cmd) begin
        so_o <= sh_q[W-1];
        sh_q <= {sh_q[W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/serstat_flags.sv
module serstat_flags #(
  parameter int NPORTS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPORTS-1:0] port_en_i,
  input  logic [NPORTS-1:0] fifo_err_i,
  input  logic [NPORTS-1:0] link_pass_i,
  input  logic              jabber_i,
  input  logic              clr_err_i,
  input  logic              clr_jab_i,
  output logic [NPORTS-1:0] err_q,
  output logic              jab_q,
  output logic [NPORTS-1:0] hold_q
);
  logic [NPORTS-1:0] en_q;
  logic [NPORTS-1:0] en_rise;

  assign en_rise = port_en_i & ~en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '1;
      err_q  <= '0;
      jab_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      en_q   <= port_en_i;
      // a new event always wins over the read clear
      err_q  <= clr_err_i ? fifo_err_i : (err_q | fifo_err_i);
      jab_q  <= clr_jab_i ? jabber_i : (jab_q | jabber_i);
      // hold released once the link logic reports fail for the port
      hold_q <= en_rise | (hold_q & link_pass_i);
    end
  end
endmodule

// File: rtl/serstat_packer.sv
module serstat_packer #(
  parameter int NPORTS = 8
) (
  input  logic [NPORTS-1:0] vec_i,
  output logic [7:0]        byte_o
);
  localparam int STRIDE = 8 / NPORTS;

  always_comb begin
    byte_o = '0;
    for (int k = 0; k < NPORTS; k++) begin
      byte_o[k*STRIDE + STRIDE - 1] = vec_i[k];
    end
  end
endmodule

// File: rtl/serstat_resp.sv
module serstat_resp
  import serstat_pkg::*;
#(
  parameter int         NPORTS  = 8,
  parameter logic [3:0] VERSION = 4'h5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_i,
  input  logic              bit_stb_i,
  input  logic              si_i,
  output logic              so_o,
  input  logic [NPORTS-1:0] port_en_i,
  input  logic [NPORTS-1:0] part_i,
  input  logic [NPORTS-1:0] fifo_err_i,
  input  logic [NPORTS-1:0] link_pass_i,
  input  logic [NPORTS-1:0] pol_rev_i,
  input  logic [NPORTS-1:0] pol_fix_en_i,
  input  logic              jabber_i,
  output logic [NPORTS-1:0] link_force_o
);
  logic [BYTE_W-1:0] cmd;
  logic [BYTE_W-1:0] resp;
  logic              load;
  logic [NPORTS-1:0] err_q;
  logic              jab_q;
  logic [NPORTS-1:0] hold_q;
  logic              clr_err;
  logic              clr_jab;
  logic [NPORTS-1:0] vec [NUM_VEC];
  logic [BYTE_W-1:0] pk  [NUM_VEC];

  serstat_shifter #(.W(BYTE_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .cs_i      (cs_i),
    .bit_stb_i (bit_stb_i),
    .si_i      (si_i),
    .resp_i    (resp),
    .cmd_o     (cmd),
    .load_o    (load),
    .so_o      (so_o)
  );

  assign clr_err = load && (cmd == OP_ERR);
  assign clr_jab = load && (cmd == OP_JAB);

  serstat_flags #(.NPORTS(NPORTS)) u_flags (
    .clk         (clk),
    .rst         (rst),
    .port_en_i   (port_en_i),
    .fifo_err_i  (fifo_err_i),
    .link_pass_i (link_pass_i),
    .jabber_i    (jabber_i),
    .clr_err_i   (clr_err),
    .clr_jab_i   (clr_jab),
    .err_q       (err_q),
    .jab_q       (jab_q),
    .hold_q      (hold_q)
  );

  assign link_force_o = hold_q;

  // per-port status vectors, before byte packing
  assign vec[V_PART] = ~part_i | ~port_en_i;
  assign vec[V_ERR]  = err_q;
  assign vec[V_LINK] = link_pass_i & ~hold_q;
  assign vec[V_POL]  = pol_rev_i & pol_fix_en_i;

  for (genvar g = 0; g < NUM_VEC; g++) begin : g_pack
    serstat_packer #(.NPORTS(NPORTS)) u_pk (
      .vec_i  (vec[g]),
      .byte_o (pk[g])
    );
  end

  always_comb begin
    case (cmd)
      OP_PART: resp = pk[V_PART];
      OP_ERR:  resp = pk[V_ERR];
      OP_LINK: resp = pk[V_LINK];
      OP_POL:  resp = pk[V_POL];
      OP_JAB:  resp = {jab_q, 7'b0};
      OP_VER:  resp = {4'h0, VERSION};
      default: resp = '0;
    endcase
  end
endmodule

// File: rtl/serstat_chk.sv
module serstat_chk #(
  parameter int NPORTS = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_i,
  input logic              bit_stb_i,
  input logic              so_o,
  input logic [NPORTS-1:0] port_en_i,
  input logic [NPORTS-1:0] fifo_err_i,
  input logic              jabber_i,
  input logic [NPORTS-1:0] err_q,
  input logic              jab_q,
  input logic [NPORTS-1:0] link_force_o
);
  logic [NPORTS-1:0] en_prev;
  logic [NPORTS-1:0] rise_c;

  always_ff @(posedge clk) begin
    if (rst) en_prev <= '1;
    else     en_prev <= port_en_i;
  end
  assign rise_c = port_en_i & ~en_prev;

  assert_so_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !cs_i |=> !so_o);

  assert_so_steady_R1: assert property (@(posedge clk) disable iff (rst)
    (cs_i && !bit_stb_i) |=> $stable(so_o));

  assert_err_kept_R5: assert property (@(posedge clk) disable iff (rst)
    (|fifo_err_i) |=> ((err_q & $past(fifo_err_i)) == $past(fifo_err_i)));

  assert_jab_kept_R9: assert property (@(posedge clk) disable iff (rst)
    jabber_i |=> jab_q);

  assert_force_on_R7: assert property (@(posedge clk) disable iff (rst)
    (|rise_c) |=> ((link_force_o & $past(rise_c)) == $past(rise_c)));
endmodule

bind serstat_resp serstat_chk #(.NPORTS(NPORTS)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cs_i         (cs_i),
  .bit_stb_i    (bit_stb_i),
  .so_o         (so_o),
  .port_en_i    (port_en_i),
  .fifo_err_i   (fifo_err_i),
  .jabber_i     (jabber_i),
  .err_q        (err_q),
  .jab_q        (jab_q),
  .link_force_o (link_force_o)
);

// File: tb/tb_serstat_resp.sv
`timescale 1ns/1ps
module tb_serstat_resp;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs = 1'b0, stb = 1'b0, si = 1'b0;
  logic so8, so4;
  logic [7:0] en8 = 8'hFF, part8 = 8'h00, ferr8 = 8'h00, link8 = 8'hFF;
  logic [7:0] prev8 = 8'h00, pfix8 = 8'hFF, force8;
  logic       jab8 = 1'b0;
  logic [3:0] en4 = 4'hF, part4 = 4'h0, link4 = 4'hF, force4;

  int total = 0, bad = 0;
  bit done = 1'b0;

  typedef struct { logic [7:0] exp; int which; string tag; } item_t;
  item_t sbq[$];
  logic [7:0] rx_got;
  event rx_ev;

  always #4 clk = ~clk;

  serstat_resp #(.NPORTS(8)) dut (
    .clk(clk), .rst(rst), .cs_i(cs), .bit_stb_i(stb), .si_i(si), .so_o(so8),
    .port_en_i(en8), .part_i(part8), .fifo_err_i(ferr8), .link_pass_i(link8),
    .pol_rev_i(prev8), .pol_fix_en_i(pfix8), .jabber_i(jab8), .link_force_o(force8)
  );

  serstat_resp #(.NPORTS(4)) dut4 (
    .clk(clk), .rst(rst), .cs_i(cs), .bit_stb_i(stb), .si_i(si), .so_o(so4),
    .port_en_i(en4), .part_i(part4), .fifo_err_i(4'h0), .link_pass_i(link4),
    .pol_rev_i(4'h0), .pol_fix_en_i(4'h0), .jabber_i(1'b0), .link_force_o(force4)
  );

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard as each response byte completes
  initial begin
    forever begin
      @(rx_ev);
      total++;
      if (sbq.size() == 0) begin
        bad++;
        $display("FAIL scoreboard empty act=%02h exp=none", rx_got);
      end else begin
        item_t it;
        it = sbq.pop_front();
        if (rx_got !== it.exp) begin
          bad++;
          $display("FAIL %s act=%02h exp=%02h", it.tag, rx_got, it.exp);
        end
      end
    end
  end

  // driver: one framed transfer; evt pulses fifo_err with the 8th strobe
  task automatic xfer(input logic [7:0] cmd, input logic [7:0] exp, input int which,
                      input string tag, input logic [7:0] evt, input int extra);
    logic [7:0] g8, g4;
    item_t it;
    it.exp = exp; it.which = which; it.tag = tag;
    sbq.push_back(it);
    @(negedge clk) cs = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk) begin stb = 1'b1; si = cmd[7-i]; if (i == 7) ferr8 = evt; end
      @(negedge clk) begin stb = 1'b0; ferr8 = 8'h00; end
    end
    g8[7] = so8; g4[7] = so4;
    for (int b = 6; b >= 0; b--) begin
      @(negedge clk) stb = 1'b1;
      @(negedge clk) stb = 1'b0;
      g8[b] = so8; g4[b] = so4;
    end
    @(negedge clk) stb = 1'b1;
    @(negedge clk) stb = 1'b0;
    check(so8 === 1'b0, "R1 so low after last bit", {7'b0, so8}, 8'h00);
    for (int x = 0; x < extra; x++) begin
      @(negedge clk) begin stb = 1'b1; si = 1'b1; end
      @(negedge clk) stb = 1'b0;
      check(so8 === 1'b0, "R13 extra strobe ignored", {7'b0, so8}, 8'h00);
    end
    @(negedge clk) cs = 1'b0;
    rx_got = (which == 1) ? g4 : g8;
    -> rx_ev;
    @(negedge clk);
  endtask

  task automatic pulse_err(input logic [7:0] m);
    @(negedge clk) ferr8 = m;
    @(negedge clk) ferr8 = 8'h00;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(so8 === 1'b0 && so4 === 1'b0, "R1 reset so", {6'b0, so4, so8}, 8'h00);
    check(force8 === 8'h00, "R7 reset force", force8, 8'h00);

    xfer(8'hFF, 8'h05, 0, "R10 version", 8'h00, 0);
    part8 = 8'h21;
    xfer(8'h80, 8'hDE, 0, "R2 partition", 8'h00, 0);

    pulse_err(8'h05);
    xfer(8'hA0, 8'h05, 0, "R4 error flags", 8'h00, 0);
    xfer(8'hA0, 8'h00, 0, "R5 cleared by read", 8'h00, 0);
    pulse_err(8'h03);
    xfer(8'hA0, 8'h03, 0, "R5 read with coincident event", 8'h10, 0);
    xfer(8'hA0, 8'h10, 0, "R5 coincident event kept", 8'h00, 0);

    link8 = 8'h96;
    xfer(8'hD0, 8'h96, 0, "R6 link status", 8'h00, 0);

    link8 = 8'hC3; en8 = 8'h7F; part8 = 8'hA1;
    xfer(8'h80, 8'hDE, 0, "R3 disabled reads connected", 8'h00, 0);
    xfer(8'hD0, 8'hC3, 0, "R6 disabled keeps link", 8'h00, 0);
    @(negedge clk) en8 = 8'hFF;
    @(negedge clk);
    check(force8 === 8'h80, "R7 force after re-enable", force8, 8'h80);
    xfer(8'hD0, 8'h43, 0, "R7 re-enabled reads fail", 8'h00, 0);
    @(negedge clk) link8 = 8'h43;
    @(negedge clk);
    @(negedge clk) link8 = 8'hC3;
    @(negedge clk);
    check(force8 === 8'h00, "R7 force released", force8, 8'h00);
    xfer(8'hD0, 8'hC3, 0, "R7 pass after release", 8'h00, 0);

    prev8 = 8'hF0; pfix8 = 8'h3C;
    xfer(8'hE0, 8'h30, 0, "R8 polarity", 8'h00, 0);

    @(negedge clk) jab8 = 1'b1;
    @(negedge clk) jab8 = 1'b0;
    xfer(8'hF0, 8'h80, 0, "R9 jabber set", 8'h00, 0);
    xfer(8'hF0, 8'h00, 0, "R9 jabber cleared", 8'h00, 0);

    pulse_err(8'h08);
    xfer(8'h12, 8'h00, 0, "R11 unknown opcode", 8'h00, 0);
    xfer(8'hA0, 8'h08, 0, "R11 flags not cleared", 8'h00, 0);

    part4 = 4'b0101;
    xfer(8'h80, 8'h88, 1, "R12 four-port partition", 8'h00, 0);
    link4 = 4'b0011;
    xfer(8'hD0, 8'h0A, 1, "R12 four-port link", 8'h00, 0);
    xfer(8'hFF, 8'h05, 1, "R12 four-port version", 8'h00, 0);

    xfer(8'hFF, 8'h05, 0, "R13 frame with trailing strobes", 8'h00, 3);
    @(negedge clk);
    check(so8 === 1'b0, "R1 idle after deselect", {7'b0, so8}, 8'h00);

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule